// File: doc/BRIEF.md
# Focal Point Phase Calculator

This block turns one packed focal-point entry into a drive setting for every transducer of a fixed array. A start pulse captures four 16-bit entry words and a 32-bit sound speed given as two 16-bit halves. The block then visits the transducers one after another in ascending index order. For each one it produces an 8-bit intensity and an 8-bit phase, presented together with the transducer index and a one-cycle valid flag.

The entry packs three signed 18-bit coordinates and an 8-bit intensity. The coordinate fields straddle word boundaries. For each transducer the block forms the squared Euclidean distance from the focal point to the transducer position, which comes from a small computed constant table. It takes the floor integer square root of that distance with a bit-serial restoring algorithm. The root is shifted left by 18 and divided by the sound speed in a restoring divider, and the low 8 bits of the quotient become the phase.

The position table places transducer k at x = (k mod NX)·PITCH, y = (k div NX)·PITCH, z = 0, as signed 16-bit values. The defaults are NX = 4, NY = 3 and PITCH = 406, giving 12 transducers.

Top module: `focal_phase_calc`

## Requirements
- R1: After reset, busy, out_valid and done are low.
- R2: Coordinate X is 18 bits: entry word 0 gives bits 15:0 and word 1 bits 1:0 give bits 17:16.
- R3: Coordinate Y is 18 bits: word 1 bits 15:2 give bits 13:0 and word 2 bits 3:0 give bits 17:14.
- R4: Coordinate Z is 18 bits: word 2 bits 15:4 give bits 11:0 and word 3 bits 5:0 give bits 17:12.
- R5: The intensity of every output pair equals word 3 bits 13:6 of the captured entry.
- R6: All three coordinates are two's complement, so a set bit 17 makes the value negative.
- R7: The phase equals the low 8 bits of (floor(sqrt(dx²+dy²+dz²)) · 2^18) / speed, using integer division and the table position of that transducer.
- R8: The sound speed is speed_hi·65536 + speed_lo, captured at start.
- R9: After each start, exactly NX·NY pairs are emitted, with out_idx running 0, 1, 2, … in order, and out_valid only while busy.
- R10: done is high together with the valid pair of the last transducer, and busy is low in the next cycle.
- R11: A start pulse while busy has no effect. The run continues with the entry and speed captured first.
- R12: A sound speed of zero gives phase 0xFF.
- R13: The first pair becomes valid 59 clock edges after the edge that samples start. Each later pair follows the previous one by exactly 60 cycles (sqrt width 20 + divide width 38 + 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture entry and speed and begin a run (ignored while busy) |
| ent_w0 | input | 16 | Entry word 0 |
| ent_w1 | input | 16 | Entry word 1 |
| ent_w2 | input | 16 | Entry word 2 |
| ent_w3 | input | 14 | Entry word 3, bits 13:0 |
| speed_hi | input | 16 | Upper half of the sound speed |
| speed_lo | input | 16 | Lower half of the sound speed |
| busy | output | 1 | Run in progress |
| out_valid | output | 1 | Output pair valid this cycle |
| out_idx | output | 4 | Transducer index of the current pair |
| out_intensity | output | 8 | Intensity of the current pair |
| out_phase | output | 8 | Phase of the current pair |
| done | output | 1 | High with the last pair of a run |

## Verification
A corrupted coordinate, a wrong square root or a wrong divider remainder shows up as a wrong phase on the very next valid pair. A stuck step counter shifts the 60-cycle spacing between pairs, and the next valid beat exposes it. An index that skips or repeats, or a done that misses the last transducer, shows within one run of 12 pairs. The random entries put arbitrary bits in every packed field, and directed cases cover extreme negative coordinates, a zero speed, a speed of one and a start issued in the middle of a run.

// File: rtl/focal_phase_calc.sv
module focal_phase_calc #(
  parameter int NX = 4,
  parameter int NY = 3,
  parameter int PITCH = 406,
  parameter int SHIFT = 18,
  localparam int NT = NX * NY,
  localparam int KW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   ent_w0,
  input  logic [15:0]   ent_w1,
  input  logic [15:0]   ent_w2,
  input  logic [13:0]   ent_w3,
  input  logic [15:0]   speed_hi,
  input  logic [15:0]   speed_lo,
  output logic          busy,
  output logic          out_valid,
  output logic [KW-1:0] out_idx,
  output logic [7:0]    out_intensity,
  output logic [7:0]    out_phase,
  output logic          done
);
  localparam int CW = 18;
  localparam int DW = CW + 1;
  localparam int SQW = 2 * DW + 2;
  localparam int RTW = SQW / 2;
  localparam int NW = RTW + SHIFT;
  localparam int RMW = RTW + 2;
  localparam int CNW = $clog2(NW + 1);
  localparam int PERIOD = RTW + NW + 2;

  typedef enum logic [2:0] {S_IDLE, S_DIST, S_SQRT, S_DIV, S_EMIT} st_t;

  function automatic logic signed [15:0] pos_x(input int k);
    return 16'((k % NX) * PITCH);
  endfunction

  function automatic logic signed [15:0] pos_y(input int k);
    return 16'((k / NX) * PITCH);
  endfunction

  st_t st;
  logic [KW-1:0]  k;
  logic [CW-1:0]  x_q, y_q, z_q;
  logic [7:0]     amp_q;
  logic [31:0]    spd_q;
  logic [SQW-1:0] rad;
  logic [RMW-1:0] rem;
  logic [RTW-1:0] root;
  logic [NW-1:0]  num;
  logic [31:0]    drem;
  logic [7:0]     quo;
  logic [CNW-1:0] cnt;

  wire [CW-1:0] x_in = {ent_w1[1:0], ent_w0};
  wire [CW-1:0] y_in = {ent_w2[3:0], ent_w1[15:2]};
  wire [CW-1:0] z_in = {ent_w3[5:0], ent_w2[15:4]};

  logic signed [DW-1:0] dx, dy, dz;
  logic signed [2*DW-1:0] sq_x, sq_y, sq_z;
  logic [SQW-1:0] d2;

  assign dx = DW'($signed(x_q)) - DW'(pos_x(int'(k)));
  assign dy = DW'($signed(y_q)) - DW'(pos_y(int'(k)));
  assign dz = DW'($signed(z_q));
  assign sq_x = dx * dx;
  assign sq_y = dy * dy;
  assign sq_z = dz * dz;
  assign d2 = SQW'($unsigned(sq_x)) + SQW'($unsigned(sq_y)) + SQW'($unsigned(sq_z));

  logic [RMW+1:0] s_cand, s_trial;
  logic           s_ge;
  logic [RTW-1:0] root_nx;

  assign s_cand  = {rem, rad[SQW-1 -: 2]};
  assign s_trial = {2'b00, root, 2'b01};
  assign s_ge    = s_cand >= s_trial;
  assign root_nx = {root[RTW-2:0], s_ge};

  logic [32:0] d_cand;
  logic        d_ge;

  assign d_cand = {drem, num[NW-1]};
  assign d_ge   = d_cand >= {1'b0, spd_q};

  assign busy          = st != S_IDLE;
  assign out_valid     = st == S_EMIT;
  assign out_idx       = k;
  assign out_intensity = amp_q;
  assign out_phase     = quo;
  assign done          = out_valid && (k == KW'(NT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      k     <= '0;
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
      amp_q <= '0;
      spd_q <= '0;
      rad   <= '0;
      rem   <= '0;
      root  <= '0;
      num   <= '0;
      drem  <= '0;
      quo   <= '0;
      cnt   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          x_q   <= x_in;
          y_q   <= y_in;
          z_q   <= z_in;
          amp_q <= ent_w3[13:6];
          spd_q <= {speed_hi, speed_lo};
          k     <= '0;
          st    <= S_DIST;
        end
        S_DIST: begin
          rad  <= d2;
          rem  <= '0;
          root <= '0;
          cnt  <= '0;
          st   <= S_SQRT;
        end
        S_SQRT: begin
          rad  <= rad << 2;
          rem  <= s_ge ? RMW'(s_cand - s_trial) : RMW'(s_cand);
          root <= root_nx;
          cnt  <= cnt + 1'b1;
          if (cnt == CNW'(RTW - 1)) begin
            num  <= {root_nx, {SHIFT{1'b0}}};
            drem <= '0;
            cnt  <= '0;
            st   <= S_DIV;
          end
        end
        S_DIV: begin
          num  <= num << 1;
          drem <= d_ge ? 32'(d_cand - {1'b0, spd_q}) : 32'(d_cand);
          quo  <= {quo[6:0], d_ge};
          cnt  <= cnt + 1'b1;
          if (cnt == CNW'(NW - 1)) st <= S_EMIT;
        end
        S_EMIT: begin
          if (k == KW'(NT - 1)) st <= S_IDLE;
          else begin
            k  <= k + 1'b1;
            st <= S_DIST;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module focal_phase_calc_chk #(
  parameter int NT = 12,
  parameter int KW = 4,
  parameter int LAT = 60
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          out_valid,
  input logic [KW-1:0] out_idx,
  input logic [7:0]    out_phase,
  input logic          done,
  input logic [31:0]   spd_q
);
  logic          seen;
  logic [KW-1:0] last;
  logic [15:0]   gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0;
      last <= '0;
      gap  <= '0;
    end else if (out_valid) begin
      seen <= !done;
      last <= out_idx;
      gap  <= 16'd1;
    end else if (busy) begin
      gap <= gap + 16'd1;
    end
  end

  p_valid_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);
  p_first_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !seen |-> out_idx == '0);
  p_idx_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && seen |-> out_idx == last + 1'b1);
  p_done_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid && out_idx == KW'(NT - 1));
  p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_speed_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(spd_q));
  p_zero_speed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && spd_q == 32'd0 |-> out_phase == 8'hFF);
  p_gap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && seen |-> gap == 16'(LAT));
endmodule

bind focal_phase_calc focal_phase_calc_chk #(.NT(NT), .KW(KW), .LAT(PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .out_valid(out_valid),
  .out_idx(out_idx), .out_phase(out_phase), .done(done), .spd_q(spd_q)
);

// File: tb/focal_phase_calc_bench.sv
`timescale 1ns/1ps
module focal_phase_calc_bench;
  localparam int NX = 4;
  localparam int NT = 12;
  localparam int PITCH = 406;
  localparam int PERIOD = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] ent_w0 = '0, ent_w1 = '0, ent_w2 = '0;
  logic [13:0] ent_w3 = '0;
  logic [15:0] speed_hi = '0, speed_lo = '0;
  logic busy, out_valid, done;
  logic [3:0] out_idx;
  logic [7:0] out_intensity, out_phase;

  int n_tests = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  focal_phase_calc u_focal_phase_calc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ent_w0(ent_w0), .ent_w1(ent_w1), .ent_w2(ent_w2), .ent_w3(ent_w3),
    .speed_hi(speed_hi), .speed_lo(speed_lo),
    .busy(busy), .out_valid(out_valid), .out_idx(out_idx),
    .out_intensity(out_intensity), .out_phase(out_phase), .done(done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint sx18(input logic [17:0] v);
    return v[17] ? longint'(v) - 262144 : longint'(v);
  endfunction

  function automatic longint isqrt(input longint v);
    longint r = 0;
    for (int b = 21; b >= 0; b--) begin
      longint t = r | (longint'(1) << b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

  function automatic int ref_phase(input int k, input logic [15:0] w0, input logic [15:0] w1,
                                   input logic [15:0] w2, input logic [13:0] w3,
                                   input logic [31:0] spd);
    longint x = sx18({w1[1:0], w0});
    longint y = sx18({w2[3:0], w1[15:2]});
    longint z = sx18({w3[5:0], w2[15:4]});
    longint px = (k % NX) * PITCH;
    longint py = (k / NX) * PITCH;
    longint d2 = (x - px) * (x - px) + (y - py) * (y - py) + z * z;
    longint q;
    if (spd == 0) return 255;
    q = (isqrt(d2) << 18) / longint'(spd);
    return int'(q & 255);
  endfunction

  task automatic run(input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2,
                     input logic [13:0] w3, input logic [15:0] hi, input logic [15:0] lo,
                     input bit intr, input string tag);
    int c = 0;
    int prev = 0;
    logic [31:0] spd = {hi, lo};
    @(negedge clk);
    ent_w0 = w0; ent_w1 = w1; ent_w2 = w2; ent_w3 = w3;
    speed_hi = hi; speed_lo = lo;
    start = 1'b1;
    for (int n = 0; n < NT; n++) begin
      do begin
        @(negedge clk);
        c++;
        if (intr && c == 100) begin
          start = 1'b1;
          ent_w0 = ~w0; ent_w1 = ~w1; ent_w2 = ~w2; ent_w3 = ~w3;
          speed_hi = hi ^ 16'h0003; speed_lo = lo + 16'd77;
        end else start = 1'b0;
        if (c > 3000) begin
          chk("R9 timeout", 0, 1);
          return;
        end
      end while (!out_valid);
      chk({tag, " R13 spacing"}, c - prev, PERIOD);
      prev = c;
      chk({tag, " R9 index"}, out_idx, n);
      chk({tag, " R5 intensity"}, out_intensity, w3[13:6]);
      chk({tag, " R7 phase"}, out_phase, ref_phase(n, w0, w1, w2, w3, spd));
      chk({tag, " R10 done"}, done, n == NT - 1);
      if (intr) chk({tag, " R11 busy ignored"}, out_phase, ref_phase(n, w0, w1, w2, w3, spd));
    end
    @(negedge clk);
    chk({tag, " R10 idle"}, busy, 0);
    chk({tag, " R9 no extra"}, out_valid, 0);
  endtask

  task automatic run_xyz(input int x, input int y, input int z, input int amp,
                         input logic [15:0] hi, input logic [15:0] lo, input string tag);
    logic [17:0] xs = 18'(x);
    logic [17:0] ys = 18'(y);
    logic [17:0] zs = 18'(z);
    run(xs[15:0], {ys[13:0], xs[17:16]}, {zs[11:0], ys[17:14]},
        {8'(amp), zs[17:12]}, hi, lo, 1'b0, tag);
  endtask

  initial begin
    void'($urandom(32'd7431));
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 valid", out_valid, 0);
    chk("R1 done", done, 0);
    rst_n = 1'b1;

    run_xyz(0, 0, 0, 200, 16'h0005, 16'h3020, "origin R8");
    run_xyz(-131072, 0, 0, 1, 16'h0005, 16'h3020, "xneg R2 R6");
    run_xyz(131071, 0, 0, 255, 16'h0002, 16'h0000, "xpos R2");
    run_xyz(0, -5, 0, 17, 16'h0000, 16'hF000, "yneg R3 R6");
    run_xyz(0, 131071, 0, 90, 16'h0001, 16'h0000, "ypos R3 R8");
    run_xyz(0, 0, -131072, 33, 16'h0004, 16'h1234, "zneg R4 R6");
    run_xyz(812, 406, 70000, 128, 16'h0000, 16'h0001, "speed1 R7");
    run_xyz(-1000, 2000, -3000, 64, 16'h0000, 16'h0000, "zero R12");
    run(16'h1234, 16'h5678, 16'h9ABC, 14'h1DEF, 16'h0005, 16'h4000, 1'b1, "restart R11");

    for (int i = 0; i < 24; i++) begin
      logic [15:0] hi = (i % 3 == 0) ? 16'($urandom_range(0, 2)) : 16'($urandom);
      run(16'($urandom), 16'($urandom), 16'($urandom), 14'($urandom),
          hi, 16'($urandom), 1'b0, "rand R7");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule